// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This engine sits on the controller side of an 8-bit parallel flash bus and erases one block on a single request. A one-clock `start` pulse carries the block number. The engine then runs these steps without further help:

- It issues the erase-setup command and two address bytes that place the block number in the upper address bits.
- It issues the erase-confirm command, which starts the erase inside the device.
- It writes the status command once and keeps reading status until the device reports ready.
- It classifies the outcome, sends the read command so that later accesses see array data again, and pulses `done` with the result flags.

Every bus cycle uses the same strobe timing. There is a setup clock, then `STROBE` clocks with the strobe low, then a hold clock. The data byte and the latch qualifiers stay steady from the setup clock to the end of the hold clock. A programmable clock limit bounds the time spent polling. If the ready bit has not appeared by then, the poll stops with a timeout. Requests that arrive while the engine is active are dropped.

Top module: `erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_cle`, `bus_ale` and `bus_oe` are 0, and both `bus_we_n` and `bus_re_n` are 1.
- R2: The first write cycle after an accepted `start` carries command 60h with `bus_cle`=1 and `bus_ale`=0.
- R3: Two address cycles follow with `bus_ale`=1 and `bus_cle`=0. The block number sits at address bits 12 and up, and bits 8..11 are zero. The first byte is address bits 15..8, which is {blk[3:0],4'h0}. The second byte is address bits 23..16, which is {5'b0,blk[6:4]}.
- R4: Command D0h comes next, followed by exactly one status command 70h, both with `bus_cle`=1.
- R5: In every write cycle `bus_we_n` is low for exactly `STROBE` (default 3) consecutive clocks. `bus_dout` does not change while the strobe is low or in the clock in which the strobe rises. `bus_cle` and `bus_ale` are never 1 together. `bus_we_n` and `bus_re_n` are never low together.
- R6: After 70h the engine performs read cycles (`bus_re_n` low, `bus_oe`=0). It samples `bus_din` in the last low clock and keeps reading until a sampled byte has bit 6 = 1. The number of reads equals the position of the first ready status.
- R7: With a ready status in which bit 7 = 1 and bit 0 = 0, the result is `res_pass`=1 and `res_fail`=`res_prot`=`res_tmo`=0.
- R8: With a ready status in which bit 7 = 1 and bit 0 = 1, the result is `res_fail`=1 with `res_pass`=`res_prot`=`res_tmo`=0.
- R9: With a ready status in which bit 7 = 0, the result is `res_fail`=1 and `res_prot`=1 whatever bit 0 holds.
- R10: The timeout counter counts clocks in the poll phase. The first non-ready read that completes with the count at or above `tmo_limit` ends polling with `res_fail`=1 and `res_tmo`=1. With `tmo_limit`=0, exactly one read takes place.
- R11: The last write cycle of every operation, including a timed-out one, is command 00h with `bus_cle`=1. Each operation makes exactly six write cycles.
- R12: `done` is high for exactly one clock per operation, and the result flags are valid in that clock. `busy` is 1 from the clock after `start` until `done`, and 0 after `done`.
- R13: A `start` pulse while `busy`=1 is ignored. It changes neither the address bytes of the running operation nor the count of `done` pulses, and it does not begin a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request to erase a block |
| blk_num | input | BLK_W | Block number, captured with `start` |
| tmo_limit | input | TMO_W | Poll-phase clock limit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| res_pass | output | 1 | Erase finished without error |
| res_fail | output | 1 | Erase failed (error, protected or timeout) |
| res_prot | output | 1 | Device reported write protection |
| res_tmo | output | 1 | Ready bit never appeared within the limit |
| bus_cle | output | 1 | Command latch qualifier |
| bus_ale | output | 1 | Address latch qualifier |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_oe | output | 1 | Controller drives the data bus |
| bus_dout | output | 8 | Byte driven to the device |
| bus_din | input | 8 | Byte returned by the device |

## Verification
The hardest situations to reach from the ports are the ones where the device reply changes from one read to the next. Examples are a ready bit that shows up only on the Nth read, and a poll that runs into the clock limit just as a read completes. The bench models the device as a status responder. It counts completed read strobes and returns busy bytes until a read count drawn from the random stream, then a ready byte whose protection and error bits are also drawn. Directed runs set this up with a ready status on the first read, a device that never becomes ready, and a zero limit. A further run fires a stray request in the middle of an operation.

// File: rtl/erase_pkg.sv
package erase_pkg;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_ARRAY_READ  = 8'h00;

    localparam int ST_READY_BIT = 6;
    localparam int ST_WP_N_BIT  = 7;
    localparam int ST_ERR_BIT   = 0;

    localparam int ADDR_BITS = 24;
    localparam int BLK_LSB   = 12;

    typedef enum logic [1:0] {
        CYC_CMD,
        CYC_ADDR,
        CYC_READ
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e  kind;
        logic [7:0] data;
    } cyc_req_t;

    typedef struct packed {
        logic pass;
        logic fail;
        logic prot;
        logic tmo;
    } erase_res_t;

    localparam erase_res_t RES_NONE    = '{pass: 1'b0, fail: 1'b0, prot: 1'b0, tmo: 1'b0};
    localparam erase_res_t RES_TIMEOUT = '{pass: 1'b0, fail: 1'b1, prot: 1'b0, tmo: 1'b1};

    function automatic erase_res_t judge_status(input logic [7:0] st);
        erase_res_t r;
        r = RES_NONE;
        if (!st[ST_WP_N_BIT]) begin
            r.fail = 1'b1;
            r.prot = 1'b1;
        end else if (st[ST_ERR_BIT]) begin
            r.fail = 1'b1;
        end else begin
            r.pass = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [ADDR_BITS-1:0] blk_to_addr(input logic [15:0] blk_ext);
        logic [ADDR_BITS-1:0] wide;
        wide = {{(ADDR_BITS-16){1'b0}}, blk_ext};
        return wide << BLK_LSB;
    endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import erase_pkg::*;
#(
    parameter int STROBE = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  cyc_req_t   req,
    output logic       ack,
    output logic [7:0] rd_data,
    output logic       bus_cle,
    output logic       bus_ale,
    output logic       bus_we_n,
    output logic       bus_re_n,
    output logic       bus_oe,
    output logic [7:0] bus_dout,
    input  logic [7:0] bus_din
);

    localparam int CW = $clog2(STROBE + 1);
    localparam logic [CW-1:0] LAST = CW'(STROBE - 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_e;

    phase_e     ph;
    cyc_req_t   cur;
    logic [CW-1:0] cnt;
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cur  <= '{kind: CYC_CMD, data: 8'h00};
            cnt  <= '0;
            rd_q <= 8'h00;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur <= req;
                        ph  <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    cnt <= '0;
                    ph  <= PH_LOW;
                end
                PH_LOW: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        ph <= PH_HOLD;
                        if (cur.kind == CYC_READ) rd_q <= bus_din;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    logic is_wr;
    assign is_wr    = (cur.kind != CYC_READ);
    assign bus_oe   = (ph != PH_IDLE) && is_wr;
    assign bus_cle  = bus_oe && (cur.kind == CYC_CMD);
    assign bus_ale  = bus_oe && (cur.kind == CYC_ADDR);
    assign bus_dout = bus_oe ? cur.data : 8'h00;
    assign bus_we_n = !((ph == PH_LOW) && is_wr);
    assign bus_re_n = !((ph == PH_LOW) && !is_wr);
    assign ack      = (ph == PH_HOLD);
    assign rd_data  = rd_q;

endmodule

// File: rtl/erase_poll_timer.sv
module erase_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);

endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_pkg::*;
#(
    parameter int BLK_W  = 7,
    parameter int TMO_W  = 16,
    parameter int STROBE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BLK_W-1:0] blk_num,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             busy,
    output logic             done,
    output logic             res_pass,
    output logic             res_fail,
    output logic             res_prot,
    output logic             res_tmo,
    output logic             bus_cle,
    output logic             bus_ale,
    output logic             bus_we_n,
    output logic             bus_re_n,
    output logic             bus_oe,
    output logic [7:0]       bus_dout,
    input  logic [7:0]       bus_din
);

    typedef enum logic [3:0] {
        S_IDLE, S_SETUP, S_ADDR_LO, S_ADDR_HI, S_CONFIRM,
        S_STAT, S_POLL, S_EXIT, S_DONE
    } state_e;

    state_e              state;
    logic [BLK_W-1:0]    blk_q;
    erase_res_t          res_q;
    logic [ADDR_BITS-1:0] addr;
    logic                cyc_valid;
    cyc_req_t            cyc_req;
    logic                cyc_ack;
    logic [7:0]          cyc_rd;
    logic                tmo_hit;

    assign addr = blk_to_addr(16'(blk_q));

    always_comb begin
        cyc_valid = 1'b1;
        cyc_req   = '{kind: CYC_CMD, data: OP_ARRAY_READ};
        case (state)
            S_SETUP:   cyc_req = '{kind: CYC_CMD,  data: OP_ERASE_SETUP};
            S_ADDR_LO: cyc_req = '{kind: CYC_ADDR, data: addr[15:8]};
            S_ADDR_HI: cyc_req = '{kind: CYC_ADDR, data: addr[23:16]};
            S_CONFIRM: cyc_req = '{kind: CYC_CMD,  data: OP_ERASE_GO};
            S_STAT:    cyc_req = '{kind: CYC_CMD,  data: OP_STATUS};
            S_POLL:    cyc_req = '{kind: CYC_READ, data: 8'h00};
            S_EXIT:    cyc_req = '{kind: CYC_CMD,  data: OP_ARRAY_READ};
            default:   cyc_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            blk_q <= '0;
            res_q <= RES_NONE;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        blk_q <= blk_num;
                        res_q <= RES_NONE;
                        state <= S_SETUP;
                    end
                end
                S_SETUP:   if (cyc_ack) state <= S_ADDR_LO;
                S_ADDR_LO: if (cyc_ack) state <= S_ADDR_HI;
                S_ADDR_HI: if (cyc_ack) state <= S_CONFIRM;
                S_CONFIRM: if (cyc_ack) state <= S_STAT;
                S_STAT:    if (cyc_ack) state <= S_POLL;
                S_POLL: begin
                    if (cyc_ack) begin
                        if (cyc_rd[ST_READY_BIT]) begin
                            res_q <= judge_status(cyc_rd);
                            state <= S_EXIT;
                        end else if (tmo_hit) begin
                            res_q <= RES_TIMEOUT;
                            state <= S_EXIT;
                        end
                    end
                end
                S_EXIT:    if (cyc_ack) state <= S_DONE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    flash_bus_cycle #(.STROBE(STROBE)) u_cyc (
        .clk      (clk),
        .rst      (rst),
        .req_valid(cyc_valid),
        .req      (cyc_req),
        .ack      (cyc_ack),
        .rd_data  (cyc_rd),
        .bus_cle  (bus_cle),
        .bus_ale  (bus_ale),
        .bus_we_n (bus_we_n),
        .bus_re_n (bus_re_n),
        .bus_oe   (bus_oe),
        .bus_dout (bus_dout),
        .bus_din  (bus_din)
    );

    erase_poll_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .run    (state == S_POLL),
        .limit  (tmo_limit),
        .expired(tmo_hit)
    );

    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign res_pass = res_q.pass;
    assign res_fail = res_q.fail;
    assign res_prot = res_q.prot;
    assign res_tmo  = res_q.tmo;

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
    parameter int STROBE = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       res_pass,
    input logic       res_fail,
    input logic       res_prot,
    input logic       res_tmo,
    input logic       bus_cle,
    input logic       bus_ale,
    input logic       bus_we_n,
    input logic       bus_re_n,
    input logic       bus_oe,
    input logic [7:0] bus_dout
);

    logic [15:0] low_cnt;
    logic        prev_we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            prev_we_n <= 1'b1;
        end else begin
            prev_we_n <= bus_we_n;
            low_cnt   <= bus_we_n ? 16'd0 : low_cnt + 16'd1;
        end
    end

    // R5: no two latch qualifiers and no two strobes at once
    p_latch_excl_r5: assert property (@(posedge clk) disable iff (rst) !(bus_cle && bus_ale));
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst) !(!bus_we_n && !bus_re_n));
    // R5: data held while the write strobe is low and in the clock it rises
    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst) !bus_we_n |=> $stable(bus_dout));
    // R5: strobe width
    p_strobe_width_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we_n && !prev_we_n) |-> (low_cnt == 16'(STROBE)));
    // R6: bus released during reads
    p_read_release_r6: assert property (@(posedge clk) disable iff (rst) !bus_re_n |-> !bus_oe);
    // R12: one-clock done, busy drops after
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst) done |=> (!done && !busy));
    // R7/R8: exactly one of pass or fail at done
    p_result_excl_r7: assert property (@(posedge clk) disable iff (rst) done |-> (res_pass ^ res_fail));
    // R9/R10: protect and timeout are failures
    p_sub_fail_r9: assert property (@(posedge clk) disable iff (rst)
        (done && (res_prot || res_tmo)) |-> (res_fail && !(res_prot && res_tmo)));
    // R1: idle bus when not busy
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_we_n && bus_re_n && !bus_oe));

endmodule

bind erase_seq erase_seq_chk #(.STROBE(STROBE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .res_pass(res_pass),
    .res_fail(res_fail),
    .res_prot(res_prot),
    .res_tmo (res_tmo),
    .bus_cle (bus_cle),
    .bus_ale (bus_ale),
    .bus_we_n(bus_we_n),
    .bus_re_n(bus_re_n),
    .bus_oe  (bus_oe),
    .bus_dout(bus_dout)
);

// File: tb/erase_seq_tb.sv
module erase_seq_tb;

    localparam int BLK_W  = 7;
    localparam int TMO_W  = 16;
    localparam int STROBE = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [BLK_W-1:0] blk_num = '0;
    logic [TMO_W-1:0] tmo_limit = 16'd2000;
    logic             busy, done, res_pass, res_fail, res_prot, res_tmo;
    logic             bus_cle, bus_ale, bus_we_n, bus_re_n, bus_oe;
    logic [7:0]       bus_dout, bus_din;

    always #4 clk = ~clk;

    erase_seq #(.BLK_W(BLK_W), .TMO_W(TMO_W), .STROBE(STROBE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .blk_num(blk_num), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .res_pass(res_pass), .res_fail(res_fail),
        .res_prot(res_prot), .res_tmo(res_tmo), .bus_cle(bus_cle), .bus_ale(bus_ale),
        .bus_we_n(bus_we_n), .bus_re_n(bus_re_n), .bus_oe(bus_oe),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    int total = 0;
    int bad   = 0;

    // device model state
    int   k_ready = 1;
    bit   never   = 1'b0;
    bit   st_b0   = 1'b0;
    bit   st_b7   = 1'b1;
    int   reads   = 0;

    // monitor log
    logic [9:0] wlog [16];
    int   wcount   = 0;
    int   width_bad = 0;
    int   hold_bad  = 0;
    int   low_cnt   = 0;
    logic [7:0] low_data = 8'h00;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_done = 1'b0;
    int   done_cnt = 0;
    int   done_wide = 0;

    assign bus_din = bus_re_n ? 8'h00 :
                     ((!never && (reads + 1 >= k_ready)) ? {st_b7, 1'b1, 5'b0, st_b0}
                                                         : {st_b7, 1'b0, 6'b0});

    always @(negedge clk) begin
        if (!rst) begin
            if (!bus_we_n) begin
                if (low_cnt > 0 && bus_dout != low_data) hold_bad++;
                low_data = bus_dout;
                low_cnt++;
            end
            if (bus_we_n && !prev_we) begin
                if (low_cnt != STROBE) width_bad++;
                if (bus_dout != low_data) hold_bad++;
                if (wcount < 16) wlog[wcount] = {bus_cle, bus_ale, bus_dout};
                wcount++;
                low_cnt = 0;
            end
            if (bus_re_n && !prev_re) reads++;
            if (done) begin
                done_cnt++;
                if (prev_done) done_wide++;
            end
            prev_we   = bus_we_n;
            prev_re   = bus_re_n;
            prev_done = done;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_res(input bit nv, input bit b7, input bit b0);
        // {pass, fail, prot, tmo}
        if (nv)      return 4'b0101;
        if (!b7)     return 4'b0110;
        if (b0)      return 4'b0100;
        return 4'b1000;
    endfunction

    task automatic run_erase(input logic [BLK_W-1:0] blk, input int k, input bit nv,
                             input bit b7, input bit b0, input logic [TMO_W-1:0] lim,
                             input bit stray);
        int wait_cyc;
        logic [3:0] er;
        logic [3:0] got;
        k_ready = k; never = nv; st_b7 = b7; st_b0 = b0; tmo_limit = lim;
        reads = 0; wcount = 0; width_bad = 0; hold_bad = 0; done_cnt = 0; done_wide = 0;
        @(negedge clk);
        start = 1'b1; blk_num = blk;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R12 busy after start", busy, 1);
        wait_cyc = 0;
        while (!done && wait_cyc < 6000) begin
            @(negedge clk);
            wait_cyc++;
            if (stray && wait_cyc == 12) begin
                start = 1'b1; blk_num = blk ^ 7'h55;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(done == 1'b1, "R12 done reached", done, 1);
        er  = exp_res(nv, b7, b0);
        got = {res_pass, res_fail, res_prot, res_tmo};
        if (nv) chk(got == er, "R10 timeout flags", got, er);
        else if (!b7) chk(got == er, "R9 protect flags", got, er);
        else if (b0) chk(got == er, "R8 error flags", got, er);
        else chk(got == er, "R7 pass flags", got, er);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R12 idle after done", busy, 0);
        chk(done_cnt == 1 && done_wide == 0, "R12 done one clock", done_cnt, 1);
        chk(wcount == 6, "R11 six write cycles", wcount, 6);
        chk(wlog[0] == {2'b10, 8'h60}, "R2 setup command", wlog[0], {2'b10, 8'h60});
        chk(wlog[1] == {2'b01, blk[3:0], 4'h0}, "R3 address low", wlog[1], {2'b01, blk[3:0], 4'h0});
        chk(wlog[2] == {2'b01, 5'b0, blk[6:4]}, "R3 address high", wlog[2], {2'b01, 5'b0, blk[6:4]});
        chk(wlog[3] == {2'b10, 8'hD0}, "R4 confirm command", wlog[3], {2'b10, 8'hD0});
        chk(wlog[4] == {2'b10, 8'h70}, "R4 status command", wlog[4], {2'b10, 8'h70});
        chk(wlog[5] == {2'b10, 8'h00}, "R11 read command last", wlog[5], {2'b10, 8'h00});
        chk(width_bad == 0 && hold_bad == 0, "R5 strobe timing", width_bad + hold_bad, 0);
        if (nv && lim == 0) chk(reads == 1, "R10 zero limit single read", reads, 1);
        else if (nv) chk(reads >= 1, "R10 reads before timeout", reads, 1);
        else chk(reads == k, "R6 poll read count", reads, k);
        if (stray) chk(wcount == 6 && done_cnt == 1, "R13 stray start ignored", wcount, 6);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && bus_we_n && bus_re_n && !bus_cle && !bus_ale && !bus_oe,
            "R1 reset state", {busy, done, bus_we_n, bus_re_n, bus_cle, bus_ale, bus_oe}, 7'b0011000);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && bus_we_n && bus_re_n, "R1 idle after reset", busy, 0);
        // directed corners
        run_erase(7'h00, 1, 1'b0, 1'b1, 1'b0, 16'd2000, 1'b0);  // R7 ready on first read
        run_erase(7'h7F, 4, 1'b0, 1'b1, 1'b1, 16'd2000, 1'b0);  // R8
        run_erase(7'h2A, 3, 1'b0, 1'b0, 1'b1, 16'd2000, 1'b0);  // R9 protect beats error
        run_erase(7'h15, 1, 1'b1, 1'b1, 1'b0, 16'd40, 1'b0);    // R10 never ready
        run_erase(7'h33, 1, 1'b1, 1'b1, 1'b0, 16'd0, 1'b0);     // R10 zero limit
        run_erase(7'h4C, 6, 1'b0, 1'b1, 1'b0, 16'd2000, 1'b1);  // R13 stray start
        // constrained random
        for (int i = 0; i < 24; i++) begin
            run_erase(7'($urandom_range(0, 127)), int'($urandom_range(1, 10)), 1'b0,
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 16'd2000,
                      1'($urandom_range(0, 3) == 0));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule